// File: doc/BRIEF.md
# Buffered Timer Channel

A single 16-bit up-counter with two general registers, GRA and GRB. Each general register has its own buffer register. Software sets up the channel through a small register port: one address bus, a write strobe and write data, and a combinational read. The counter runs only while its run bit is set. It counts ticks from one of two sources: an internal divider of the system clock, or an external clock pin with a selectable active edge. The counter either wraps freely or returns to zero on a match with GRA or GRB.

Each general register is set up on its own, either as a compare register or as a capture register.
- In compare mode, a match at a count tick produces a one-cycle pulse on the register's match output.
- In capture mode, a chosen edge on the register's capture pin loads the counter value into it.

With buffering enabled for a register, the buffer behaves according to that register's mode:
- In compare mode, the buffer reloads the general register on every match, so the next compare value can be staged ahead of time.
- In capture mode, the previous capture moves into the buffer, so the two most recent captures are always held.

Top module: `buf_timer_ch`

## Requirements
- R1: After reset every register reads zero, and both match outputs are low.
- R2: The counter changes only on a count tick while the run bit (CTRL bit 0) is 1. Clearing the bit holds the value, and setting it again resumes from that held value.
- R3: Clock select (CTRL bits 3:1) codes 0 to 3 count internally at clk/1, clk/2, clk/4 and clk/8. These ticks come from a free-running 3-bit divider that is reset to 0 and ticks when its low `code` bits are all ones.
- R4: Clock select codes 4 to 7 count edges of `ext_clk`. Edge select (CTRL bits 5:4) is 00 for rising, 01 for falling and 1x for both. The pin passes through two synchroniser flops before edge detection.
- R5: With clear select (CTRL bits 7:6) at 00 or 11, the counter runs free and wraps from FFFF to 0000.
- R6: Clear select 01 loads 0 on a tick where the counter equals GRA; 10 does the same for GRB. The 0 replaces the increment.
- R7: When a compare-mode register equals the counter at a tick, its match output is high for exactly the following clock cycle.
- R8: With the buffer bit set for a compare-mode register (CTRL bit 8 for A, bit 9 for B), each match copies that register's buffer into it.
- R9: In capture mode (IOCTL bit 0 for A, bit 3 for B), an edge on the synchronised capture pin copies the counter into the general register. The capture edge uses IOCTL bits 2:1 for A and 5:4 for B, encoded as in R4. With buffering, the old value moves into the buffer on the same edge.
- R10: Each capture sets a sticky status bit (STATUS bit 0 for A, bit 1 for B). Writing 1 to the bit clears it, and a capture in the same cycle wins.
- R11: A write to the counter in the same cycle as a tick takes the written value. In general, a write wins over any hardware update of the same register.
- R12: The register map is: 0 CTRL, 1 IOCTL, 2 CNT, 3 GRA, 4 GRB, 5 BUFA, 6 BUFB, 7 STATUS. Writes to these addresses read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| ext_clk | input | 1 | External count clock |
| cap_a | input | 1 | Capture pin for GRA |
| cap_b | input | 1 | Capture pin for GRB |
| match_a | output | 1 | GRA compare match pulse |
| match_b | output | 1 | GRB compare match pulse |

## Verification
The assertions check four things on every cycle:
- a counter change is always an increment, a clear or a write;
- a stopped counter holds its value;
- clear-on-GRA really yields zero;
- a capture raises its flag and, when buffered, shifts the old value, and a buffered match reloads from the buffer.

Some behaviour can only be shown by the bench's scenarios, run against a cycle-level reference model:
- the divider phases;
- the synchroniser latency and edge choice on the external clock;
- the read-back values of the register map;
- the one-cycle width of match pulses under real count sequences.

// File: rtl/buf_timer_ch.sv
module buf_timer_ch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ext_clk,
  input  logic         cap_a,
  input  logic         cap_b,
  output logic         match_a,
  output logic         match_b
);
  localparam int DW = 3;

  logic [9:0]   ctrl;
  logic [5:0]   ioc;
  logic [W-1:0] cnt, gra, grb, bufa, bufb;
  logic [1:0]   st;
  logic [DW-1:0] div;
  logic [2:0]   ext_s, capa_s, capb_s;

  function automatic logic edge_hit(input logic cur, input logic prev, input logic [1:0] sel);
    case (sel)
      2'b00:   return cur & ~prev;
      2'b01:   return ~cur & prev;
      default: return cur ^ prev;
    endcase
  endfunction

  wire run   = ctrl[0];
  wire [2:0] csel = ctrl[3:1];
  wire [1:0] clr  = ctrl[7:6];
  wire bma   = ctrl[8];
  wire bmb   = ctrl[9];
  wire cm_a  = ioc[0];
  wire cm_b  = ioc[3];

  wire [DW-1:0] dmask = (DW'(1) << csel[1:0]) - DW'(1);
  wire int_tick = (div & dmask) == dmask;
  wire ext_tick = edge_hit(ext_s[1], ext_s[2], ctrl[5:4]);
  wire tick     = run & (csel[2] ? ext_tick : int_tick);

  wire hit_a   = tick & ~cm_a & (cnt == gra);
  wire hit_b   = tick & ~cm_b & (cnt == grb);
  wire clr_now = (clr == 2'b01 & hit_a) | (clr == 2'b10 & hit_b);

  wire cap_ev_a = cm_a & edge_hit(capa_s[1], capa_s[2], ioc[2:1]);
  wire cap_ev_b = cm_b & edge_hit(capb_s[1], capb_s[2], ioc[5:4]);

  wire we_ctrl = wr_en & (addr == 3'd0);
  wire we_ioc  = wr_en & (addr == 3'd1);
  wire we_cnt  = wr_en & (addr == 3'd2);
  wire we_gra  = wr_en & (addr == 3'd3);
  wire we_grb  = wr_en & (addr == 3'd4);
  wire we_bufa = wr_en & (addr == 3'd5);
  wire we_bufb = wr_en & (addr == 3'd6);
  wire we_st   = wr_en & (addr == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      ext_s  <= '0;
      capa_s <= '0;
      capb_s <= '0;
    end else begin
      div    <= div + DW'(1);
      ext_s  <= {ext_s[1:0], ext_clk};
      capa_s <= {capa_s[1:0], cap_a};
      capb_s <= {capb_s[1:0], cap_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      ioc  <= '0;
    end else begin
      if (we_ctrl) ctrl <= wr_data[9:0];
      if (we_ioc)  ioc  <= wr_data[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (we_cnt)  cnt <= wr_data;
    else if (tick)    cnt <= clr_now ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gra  <= '0;
      bufa <= '0;
    end else begin
      if (we_gra)              gra <= wr_data;
      else if (cap_ev_a)       gra <= cnt;
      else if (hit_a && bma)   gra <= bufa;
      if (we_bufa)             bufa <= wr_data;
      else if (cap_ev_a && bma) bufa <= gra;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grb  <= '0;
      bufb <= '0;
    end else begin
      if (we_grb)              grb <= wr_data;
      else if (cap_ev_b)       grb <= cnt;
      else if (hit_b && bmb)   grb <= bufb;
      if (we_bufb)             bufb <= wr_data;
      else if (cap_ev_b && bmb) bufb <= grb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      match_a <= 1'b0;
      match_b <= 1'b0;
    end else begin
      st[0]   <= cap_ev_a | (st[0] & ~(we_st & wr_data[0]));
      st[1]   <= cap_ev_b | (st[1] & ~(we_st & wr_data[1]));
      match_a <= hit_a;
      match_b <= hit_b;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = W'(ctrl);
      3'd1:    rd_data = W'(ioc);
      3'd2:    rd_data = cnt;
      3'd3:    rd_data = gra;
      3'd4:    rd_data = grb;
      3'd5:    rd_data = bufa;
      3'd6:    rd_data = bufb;
      default: rd_data = W'(st);
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(we_cnt) |-> (cnt == $past(cnt) + 1'b1) || (cnt == '0)); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !we_cnt |=> $stable(cnt)); // R2
  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    match_a && $past(clr == 2'b01) && !$past(we_cnt) |-> cnt == '0); // R6
  AST_MATCH_COMPARE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |-> $past(!cm_a)); // R7
  AST_RELOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    match_a && $past(bma && !we_gra) |-> gra == $past(bufa)); // R8
  AST_CAP_SHIFT_A: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev_a && bma && !we_bufa |=> bufa == $past(gra)); // R9
  AST_CAP_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev_a |=> st[0]); // R10
  AST_CAP_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev_b |=> st[1]); // R10
endmodule

// File: tb/buf_timer_ch_tb.sv
module buf_timer_ch_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, ext_clk = 0, cap_a = 0, cap_b = 0;
  logic [2:0] addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic match_a, match_b;
  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  buf_timer_ch u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ext_clk(ext_clk), .cap_a(cap_a), .cap_b(cap_b),
    .match_a(match_a), .match_b(match_b));

  // reference model state
  bit [9:0] m_ctrl; bit [5:0] m_io; bit [15:0] m_cnt, m_gra, m_grb, m_bufa, m_bufb;
  bit [1:0] m_st; bit m_ma, m_mb; int m_div;
  bit e1, e2, e3, a1, a2, a3, b1, b2, b3;

  function automatic bit eok(bit c, bit p, bit [1:0] s);
    if (s == 2'b00) return c && !p;
    if (s == 2'b01) return !c && p;
    return c != p;
  endfunction

  function automatic bit [15:0] m_read(bit [2:0] a);
    case (a)
      0: return {6'd0, m_ctrl};
      1: return {10'd0, m_io};
      2: return m_cnt;
      3: return m_gra;
      4: return m_grb;
      5: return m_bufa;
      6: return m_bufb;
      default: return {14'd0, m_st};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_io = 0; m_cnt = 0; m_gra = 0; m_grb = 0; m_bufa = 0; m_bufb = 0;
      m_st = 0; m_ma = 0; m_mb = 0; m_div = 0;
      {e1, e2, e3, a1, a2, a3, b1, b2, b3} = 0;
    end else begin
      int sel; bit tk, ha, hb, ca, cb, clrz;
      bit [15:0] ocnt, ogra, ogrb, obufa, obufb;
      sel = int'(m_ctrl[3:1]);
      tk = 0;
      if (m_ctrl[0]) begin
        if (sel < 4) tk = (m_div % (1 << sel)) == (1 << sel) - 1;
        else tk = eok(e2, e3, m_ctrl[5:4]);
      end
      ha = tk && !m_io[0] && m_cnt == m_gra;
      hb = tk && !m_io[3] && m_cnt == m_grb;
      ca = m_io[0] && eok(a2, a3, m_io[2:1]);
      cb = m_io[3] && eok(b2, b3, m_io[5:4]);
      clrz = (m_ctrl[7:6] == 1 && ha) || (m_ctrl[7:6] == 2 && hb);
      ocnt = m_cnt; ogra = m_gra; ogrb = m_grb; obufa = m_bufa; obufb = m_bufb;
      if (tk) m_cnt = clrz ? 16'd0 : ocnt + 1;
      if (ca) begin m_gra = ocnt; if (m_ctrl[8]) m_bufa = ogra; end
      else if (ha && m_ctrl[8]) m_gra = obufa;
      if (cb) begin m_grb = ocnt; if (m_ctrl[9]) m_bufb = ogrb; end
      else if (hb && m_ctrl[9]) m_grb = obufb;
      if (wr_en && addr == 7) m_st = m_st & ~wr_data[1:0];
      if (ca) m_st[0] = 1;
      if (cb) m_st[1] = 1;
      if (wr_en) case (addr)
        0: m_ctrl = wr_data[9:0];
        1: m_io = wr_data[5:0];
        2: m_cnt = wr_data;
        3: m_gra = wr_data;
        4: m_grb = wr_data;
        5: m_bufa = wr_data;
        6: m_bufb = wr_data;
        default: ;
      endcase
      m_ma = ha; m_mb = hb;
      m_div = (m_div + 1) % 8;
      e3 = e2; e2 = e1; e1 = ext_clk;
      a3 = a2; a2 = a1; a1 = cap_a;
      b3 = b2; b2 = b1; b1 = cap_b;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, rd_data, m_read(addr));
      chk("R7", {14'd0, match_a, match_b}, {14'd0, m_ma, m_mb});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic look(input logic [2:0] a, input string req, input logic [15:0] exp);
    @(negedge clk); addr = a;
    #2 chk(req, rd_data, exp);
  endtask

  function automatic logic [15:0] ctl(bit run, bit [2:0] cs, bit [1:0] ee, bit [1:0] cl, bit ba, bit bb);
    return {6'd0, bb, ba, cl, ee, cs, run};
  endfunction

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    for (int i = 0; i < 8; i++) look(3'(i), "R1", 16'h0000);
    chk("R1", {14'd0, match_a, match_b}, 16'h0000);

    cur_req = "R12";
    wr(3, 16'h1234); wr(4, 16'hBEEF); wr(5, 16'h0F0F); wr(6, 16'hA5A5); wr(1, 16'h0029);
    look(3, "R12", 16'h1234); look(4, "R12", 16'hBEEF);
    look(5, "R12", 16'h0F0F); look(6, "R12", 16'hA5A5); look(1, "R12", 16'h0029);
    wr(1, 16'h0000); wr(3, 16'h0000); wr(4, 16'h0000);

    cur_req = "R2";
    wr(2, 16'h0000); wr(0, ctl(1, 0, 0, 0, 0, 0));
    addr = 2; repeat (20) @(negedge clk);
    wr(0, ctl(0, 0, 0, 0, 0, 0));
    addr = 2; @(negedge clk); #2 held = rd_data;
    repeat (6) @(negedge clk);
    #2 chk("R2", rd_data, held);
    wr(0, ctl(1, 0, 0, 0, 0, 0)); addr = 2; repeat (10) @(negedge clk);

    cur_req = "R3";
    for (int s = 1; s < 4; s++) begin
      wr(0, ctl(1, 3'(s), 0, 0, 0, 0)); addr = 2; repeat (30) @(negedge clk);
    end

    cur_req = "R4";
    for (int e = 0; e < 3; e++) begin
      wr(0, ctl(1, 3'(4 + e), 2'(e), 0, 0, 0)); addr = 2;
      for (int k = 0; k < 10; k++) begin ext_clk = ~ext_clk; repeat (3) @(negedge clk); end
    end
    wr(0, 0); ext_clk = 0; wr(2, 0); repeat (4) @(negedge clk);
    wr(0, ctl(1, 4, 2, 0, 0, 0)); addr = 2;
    for (int k = 0; k < 4; k++) begin ext_clk = ~ext_clk; repeat (4) @(negedge clk); end
    repeat (6) @(negedge clk);
    #2 chk("R4", rd_data, 16'h0004);

    cur_req = "R5";
    wr(0, 0); wr(2, 16'hFFF0); wr(0, ctl(1, 0, 0, 0, 0, 0)); addr = 2; repeat (30) @(negedge clk);
    wr(0, ctl(1, 0, 0, 3, 0, 0)); wr(2, 16'hFFFE); addr = 2; repeat (6) @(negedge clk);

    cur_req = "R6";
    wr(3, 16'd5); wr(4, 16'd7); wr(2, 0);
    wr(0, ctl(1, 0, 0, 1, 0, 0)); addr = 2; repeat (30) @(negedge clk);
    wr(0, ctl(1, 1, 0, 2, 0, 0)); addr = 2; repeat (40) @(negedge clk);

    cur_req = "R8";
    wr(0, 0); wr(2, 0); wr(3, 16'd3); wr(5, 16'd9); wr(4, 16'd20);
    wr(0, ctl(1, 0, 0, 2, 1, 0)); addr = 2; repeat (60) @(negedge clk);
    wr(0, 0);
    look(3, "R8", 16'd9);

    cur_req = "R9";
    wr(3, 16'h1111); wr(2, 16'h0500); wr(0, ctl(0, 0, 0, 0, 1, 0)); wr(1, 16'h0001);
    cap_a = 1; repeat (4) @(negedge clk); cap_a = 0; repeat (4) @(negedge clk);
    look(3, "R9", 16'h0500); look(5, "R9", 16'h1111);
    look(7, "R10", 16'h0001);
    cur_req = "R10";
    wr(7, 16'h0001); look(7, "R10", 16'h0000);
    wr(1, 16'h0029); wr(0, ctl(1, 1, 0, 0, 0, 1)); addr = 4;
    for (int k = 0; k < 6; k++) begin cap_b = ~cap_b; repeat (5) @(negedge clk); end
    addr = 7; repeat (3) @(negedge clk);
    addr = 6; repeat (3) @(negedge clk);

    cur_req = "R11";
    wr(1, 0); wr(0, ctl(1, 0, 0, 0, 0, 0));
    wr(2, 16'h4000);
    addr = 2; #2 chk("R11", rd_data, 16'h4000);
    repeat (5) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule